// File: doc/BRIEF.md
# Dithered Variable-Period Pulse Generator

This block produces a train of timing events whose spacing follows a fixed-point period command. A variable-frequency or resonant power stage uses it as its switching clock. The command holds an integer count in its upper bits and a fraction in its lower bits.

A counter runs through the integer count, wraps, and marks each wrap with a one-clock pulse and a toggle of a square-wave output. The fraction cannot be shown directly by the counter. It is added into a wrapping accumulator once per period, and the period loaded on a carry is one count longer. The average period then carries the full resolution of the command.

The same scheme serves any compare value whose command is finer than the timer it drives.

Top module: `dither_period_osc`

## Requirements
- R1: Each output period lasts either the clamped integer command (command bits [15:8]) or that value plus one clock. With a zero fraction (bits [7:0]), every period equals the integer exactly.
- R2: The fraction is added into an 8-bit wrapping accumulator once per period, and a carry out of it lengthens the period being loaded by one clock. Over any 256 consecutive periods under a constant command, the total length is 256 × integer + fraction, within one clock.
- R3: The command is sampled only at a period boundary. A change in the middle of a period leaves that period's length unaffected, and the change governs the following period.
- R4: An integer command below 2 is treated as 2.
- R5: `tick` is high for exactly one clock at every counter wrap and low otherwise.
- R6: `square` inverts at every wrap, in the same cycle that `tick` is high.
- R7: A synchronous reset drives `tick` and `square` low and clears the counter and the accumulator. The first enabled clock edge after reset loads the command, and the first `tick` is seen after integer + 1 enabled edges (one extra when the first fraction add carries).
- R8: While `en` is low, the counter holds and `tick` and `square` are low. After `en` returns, the current period resumes from the held count, so the period is lengthened by exactly the number of disabled cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low holds the counter |
| period_cmd | input | 16 | Period command: integer in [15:8], fraction in [7:0] |
| tick | output | 1 | One-clock pulse at each wrap |
| square | output | 1 | Toggles at each wrap |

## Verification
The main function is tried with several fractions, each telling apart a different fault:
- zero fraction at two integers: every period must be exact;
- a fraction of one: a single lengthened period among 256;
- one half: strict alternation;
- 255: nearly every period lengthened;
- integers of 0 and 1 combined with fractions: the clamp in addition to the dither.

The sum over 256 periods separates a correct carry from one that is lost or doubled. Directed runs change the command in mid-period to expose sampling outside the boundary. Other runs pause the enable to check that the count is held, and reset during a run to show that the accumulator restarts from zero.

// File: rtl/dither_period_osc.sv
module dither_period_osc #(
  parameter int INT_W   = 8,
  parameter int FRAC_W  = 8,
  parameter int MIN_LEN = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [INT_W+FRAC_W-1:0] period_cmd,
  output logic                    tick,
  output logic                    square
);
  localparam int CMD_W = INT_W + FRAC_W;
  localparam int LEN_W = INT_W + 1;

  logic [INT_W-1:0]  cmd_int, int_clamped;
  logic [FRAC_W-1:0] cmd_frac, acc;
  logic [FRAC_W:0]   acc_sum;
  logic [LEN_W-1:0]  cnt, len, next_len;
  logic              prime, wrap, load;

  assign cmd_int     = period_cmd[CMD_W-1:FRAC_W];
  assign cmd_frac    = period_cmd[FRAC_W-1:0];
  assign int_clamped = (cmd_int < INT_W'(MIN_LEN)) ? INT_W'(MIN_LEN) : cmd_int;
  assign acc_sum     = {1'b0, acc} + {1'b0, cmd_frac};
  assign next_len    = {1'b0, int_clamped} + LEN_W'(acc_sum[FRAC_W]);
  assign wrap        = en && !prime && (cnt == len - LEN_W'(1));
  assign load        = en && (prime || wrap);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      len    <= LEN_W'(MIN_LEN);
      acc    <= '0;
      prime  <= 1'b1;
      tick   <= 1'b0;
      square <= 1'b0;
    end else begin
      tick <= wrap;
      if (!en)       square <= 1'b0;
      else if (wrap) square <= ~square;
      if (load) begin
        cnt   <= '0;
        len   <= next_len;
        acc   <= acc_sum[FRAC_W-1:0];
        prime <= 1'b0;
      end else if (en) begin
        cnt <= cnt + LEN_W'(1);
      end
    end
  end

  assert_tick_single_R5: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
  assert_square_flips_R6: assert property (@(posedge clk) disable iff (rst)
    tick |-> (square != $past(square)));
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!tick && !square));
  assert_hold_count_R8: assert property (@(posedge clk) disable iff (rst)
    (!en && !prime) |=> $stable(cnt));
  assert_len_floor_R4: assert property (@(posedge clk) disable iff (rst)
    !prime |-> (len >= LEN_W'(MIN_LEN) && cnt < len));
endmodule

// File: tb/tb_dither_period_osc.sv
module tb_dither_period_osc;
  logic clk = 1'b0, rst = 1'b1, en = 1'b0;
  logic [15:0] period_cmd = 16'h0A00;
  logic tick, square;
  int errors = 0, checks = 0, cycles = 0;

  dither_period_osc dut (.clk(clk), .rst(rst), .en(en), .period_cmd(period_cmd),
                         .tick(tick), .square(square));

  always #5 clk = ~clk;

  localparam int NV = 7;
  localparam logic [15:0] VEC_CMD [NV] = '{16'h4201, 16'h6480, 16'h94FF, 16'h0180,
                                          16'h0000, 16'h5000, 16'h0040};
  localparam int VEC_TOT [NV] = '{16897, 25728, 38143, 640, 512, 20480, 576};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic next_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick && n < 5000);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=finish", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n, total, ip, lo, sq_prev, sq_ok, rng_ok, acc_n;
    repeat (3) @(negedge clk);
    check(tick == 0 && square == 0, "R7 reset outputs", {tick, square}, 0);
    // R7: first tick after reset, accumulator cleared (10.5 -> 10, 11, 10, 11)
    period_cmd = 16'h0A80; en = 1'b1;
    @(negedge clk); rst = 1'b0;
    next_tick(n);
    check(n == 11, "R7 first tick latency", n, 11);
    next_tick(n); check(n == 11, "R7 R2 carry after reset", n, 11);
    next_tick(n); check(n == 10, "R7 R2 no carry", n, 10);
    @(negedge clk);
    check(tick == 0, "R5 tick one cycle", tick, 0);
    next_tick(n); check(n == 10, "R1 period after pulse", n + 1, 11);

    // Table walk: R1, R2, R4, R6
    for (int v = 0; v < NV; v++) begin
      period_cmd = VEC_CMD[v];
      ip = (VEC_CMD[v][15:8] < 2) ? 2 : int'(VEC_CMD[v][15:8]);
      next_tick(n);
      sq_prev = square; total = 0; sq_ok = 1; rng_ok = 1; lo = 0;
      for (int p = 0; p < 256; p++) begin
        next_tick(n);
        total += n;
        if (n != ip && n != ip + 1) begin rng_ok = 0; lo = n; end
        if (VEC_CMD[v][7:0] == 0 && n != ip) begin rng_ok = 0; lo = n; end
        if (square == sq_prev) sq_ok = 0;
        sq_prev = square;
      end
      check(rng_ok == 1, "R1 R4 period range", lo, ip);
      acc_n = total - VEC_TOT[v];
      check(acc_n <= 1 && acc_n >= -1, "R2 R4 256-period total", total, VEC_TOT[v]);
      check(sq_ok == 1, "R6 square toggle", sq_ok, 1);
    end

    // R3: mid-period command change
    period_cmd = 16'h6400;
    next_tick(n);
    repeat (10) @(negedge clk);
    period_cmd = 16'h3200;
    next_tick(n);
    check(n + 10 == 100, "R3 current period kept", n + 10, 100);
    next_tick(n);
    check(n == 50, "R3 new period next", n, 50);

    // R8: enable pause
    period_cmd = 16'h6400;
    next_tick(n); next_tick(n);
    repeat (20) @(negedge clk);
    en = 1'b0; lo = 0;
    for (int k = 0; k < 37; k++) begin
      @(negedge clk);
      if (tick || square) lo++;
    end
    check(lo == 0, "R8 outputs low while disabled", lo, 0);
    en = 1'b1;
    next_tick(n);
    check(n + 57 == 137, "R8 period stretched by pause", n + 57, 137);
    next_tick(n);
    check(n == 100, "R8 normal after resume", n, 100);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule